// File: doc/BRIEF.md
# Clock-Output Configuration Serial Target

This block is the serial control port of a multi-output clock driver. It listens on a two-wire bus (SCL and SDA, both sampled in a system clock domain much faster than the bus) and keeps seven 8-bit configuration registers. Each register bit is an enable for one clock output. The contents drive a parallel enable vector that goes to the output stage.

There is no register pointer. Every write first carries two bytes that are acknowledged and then dropped: a command byte and a count byte. The data bytes that follow land in register 0, then register 1, and so on in order. Every read first returns a byte that holds the number of registers. The register values follow in order. A STOP may end a write after any whole byte. Only whole bytes are ever stored.

SDA is driven open-drain. When `sda_oe` is high, the line is pulled low. When it is low, the line is released. Timing only needs to meet standard-mode rates (100 kbit/s or slower). Bytes are sent most significant bit first.

Top module: `clkdrv_cfg_target`

## Requirements
- R1: The target acknowledges the address byte 0xD4 (write) and 0xD5 (read), that is, 7-bit address 0x6A followed by the direction bit (0 = write, 1 = read). For any other address it gives no acknowledge, changes no register and drives nothing until the next START.
- R2: In a write, the first two bytes after the address (the command byte and the count byte) are both acknowledged, and neither changes any register.
- R3: In a write, the data bytes after the count byte are stored into registers 0, 1, ... 6 in rising order, and each one is acknowledged. Data bytes beyond register 6 are acknowledged and dropped. A register value changes only while SCL is low.
- R4: A STOP after any whole byte ends a write. A byte cut short by a STOP is never stored, and the registers after the last whole byte keep their earlier values.
- R5: After reset, registers 0 to 5 hold 0xFF and register 6 holds 0x1F.
- R6: Bits 7:5 of register 6 can never be written and always read as 0.
- R7: In a read, the target first sends the count byte 0x07. It then sends registers 0 to 6 in order, then 0xFF for every further byte. It stops driving after the controller sends a NACK.
- R8: The enable vector `out_en` (1 = enabled) maps as follows:
  - output 0 = reg5[7], output 1 = reg5[2], output 2 = reg5[6], output 3 = reg5[5], output 4 = reg5[4], output 9 = reg5[3];
  - outputs 5, 6, 7, 8 = reg6[1], reg6[2], reg6[3], reg6[4].
  
  The vector changes only when a register changes.
- R9: `sda_oe` high pulls SDA low. `sda_oe` changes only while SCL is low, and it is low whenever the target is idle.
- R10: A repeated START at any point throws away the transfer in progress and starts a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| cfg_regs | output | NREG*8 | All registers, register k in bits 8k+7:8k |
| out_en | output | 10 | Clock output enables, 1 = enabled |

## Verification
The bench goes after the transfer edges:
- A write cut short by a STOP in the middle of a byte. A design that commits partial bytes would corrupt the next register.
- Extra write bytes past register 6. A design that wraps its index would overwrite register 0.
- A repeated START in the middle of a write. A target that does not restart would take the new address as data.
- A read that runs past the last register. A design without the 0xFF fill would return stale or wrapped data.

It also writes all ones into register 6 to show that the protected bits stay at zero. It sends a wrong address followed by bytes, to show that none of them land in the registers.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;
    localparam int CNT_W  = 4;
    localparam int NOUT   = 10;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_WAIT
    } link_st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_WRITE,
        PH_READ
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        byte_t            data;
    } wr_req_t;

    function automatic byte_t reg_reset(input int idx, input int nreg);
        return (idx == nreg - 1) ? 8'h1F : 8'hFF;
    endfunction

    function automatic byte_t reg_wmask(input int idx, input int nreg);
        return (idx == nreg - 1) ? 8'h1F : 8'hFF;
    endfunction

    function automatic logic [NOUT-1:0] map_enables(input byte_t r5, input byte_t r6);
        logic [NOUT-1:0] e;
        e[0] = r5[7];
        e[1] = r5[2];
        e[2] = r5[6];
        e[3] = r5[5];
        e[4] = r5[4];
        e[5] = r6[1];
        e[6] = r6[2];
        e[7] = r6[3];
        e[8] = r6[4];
        e[9] = r5[3];
        return e;
    endfunction

endpackage

// File: rtl/clkcfg_busmon.sv
module clkcfg_busmon
    import clkcfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [1:0] stage_q [STAGES];
    logic [1:0] prev_q;
    logic [1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            stage_q[0] <= {scl_i, sda_i};
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur = stage_q[STAGES-1];

    always_comb begin
        ev.scl      = cur[1];
        ev.sda      = cur[0];
        ev.scl_rise = cur[1] & ~prev_q[1];
        ev.scl_fall = ~cur[1] & prev_q[1];
        ev.start    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
        ev.stop     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
    end

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int NREG = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_req_t            wr,
    output logic [NREG*8-1:0]  regs_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam byte_t RST_V = reg_reset(g, NREG);
        localparam byte_t MASK  = reg_wmask(g, NREG);
        byte_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RST_V;
            end else if (wr.we && wr.idx == IDX_W'(g)) begin
                q <= (wr.data & MASK) | (q & ~MASK);
            end
        end

        assign regs_o[g*8 +: 8] = q;
    end

endmodule

// File: rtl/clkcfg_link.sv
module clkcfg_link
    import clkcfg_pkg::*;
#(
    parameter int          NREG     = 7,
    parameter logic [6:0]  DEV_ADDR = 7'h6A
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [NREG*8-1:0] regs,
    output wr_req_t           wr,
    output logic              sda_oe
);

    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] CNT_WR_BEG = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_WR_END = CNT_W'(NREG + 2);

    link_st_e         st;
    phase_e           phase;
    logic [3:0]       bitcnt;
    byte_t            sh;
    logic [CNT_W-1:0] cnt;
    logic             nack;
    byte_t            tx_byte;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

    always_comb begin
        tx_byte = 8'hFF;
        if (cnt == '0) tx_byte = 8'(NREG);
        for (int i = 0; i < NREG; i++) begin
            if (cnt == CNT_W'(i + 1)) tx_byte = regs[i*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            phase  <= PH_ADDR;
            bitcnt <= '0;
            sh     <= '0;
            cnt    <= '0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.we <= 1'b0;
            if (ev.start) begin
                st     <= ST_RX;
                phase  <= PH_ADDR;
                bitcnt <= '0;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            sh     <= {sh[6:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            if (phase == PH_ADDR) begin
                                if (sh[7:1] == DEV_ADDR) begin
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                    phase  <= sh[0] ? PH_READ : PH_WRITE;
                                end else begin
                                    st <= ST_WAIT;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                st     <= ST_ACK;
                                if (cnt >= CNT_WR_BEG && cnt < CNT_WR_END) begin
                                    wr.we   <= 1'b1;
                                    wr.idx  <= IDX_W'(cnt - CNT_WR_BEG);
                                    wr.data <= sh;
                                end
                                cnt <= cnt_inc;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (phase == PH_READ) begin
                                st     <= ST_TX;
                                sh     <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                cnt    <= cnt_inc;
                            end else begin
                                st     <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= ST_RACK;
                            end else begin
                                sh     <= {sh[6:0], 1'b0};
                                sda_oe <= ~sh[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            nack <= ev.sda;
                        end else if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (nack) begin
                                st <= ST_WAIT;
                            end else begin
                                st     <= ST_TX;
                                sh     <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                cnt    <= cnt_inc;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/clkdrv_cfg_target.sv
module clkdrv_cfg_target
    import clkcfg_pkg::*;
#(
    parameter int          NREG        = 7,
    parameter int          SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_ADDR    = 7'h6A
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [NREG*8-1:0]  cfg_regs,
    output logic [NOUT-1:0]    out_en
);

    bus_ev_t ev;
    wr_req_t wr;

    clkcfg_busmon #(.STAGES(SYNC_STAGES)) u_busmon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    clkcfg_link #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_link (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .regs   (cfg_regs),
        .wr     (wr),
        .sda_oe (sda_oe)
    );

    clkcfg_regbank #(.NREG(NREG)) u_regbank (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .regs_o (cfg_regs)
    );

    assign out_en = map_enables(cfg_regs[(NREG-2)*8 +: 8], cfg_regs[(NREG-1)*8 +: 8]);

endmodule

// File: rtl/clkdrv_cfg_target_chk.sv
module clkdrv_cfg_target_chk
    import clkcfg_pkg::*;
#(
    parameter int NREG = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_regs,
    input logic [NOUT-1:0]   out_en
);

    function automatic logic [NREG*8-1:0] reset_image();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = reg_reset(i, NREG);
        return v;
    endfunction

    localparam logic [NREG*8-1:0] RST_IMG = reset_image();

    AST_RESET_IMAGE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_regs == RST_IMG) else $error("reset image"); // R5

    AST_REG_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_regs) |-> !scl_i) else $error("register change with SCL high"); // R3

    AST_LOCKED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_regs[NREG*8-1 -: 3] == 3'b000) else $error("protected bits set"); // R6

    AST_DRIVE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i) else $error("SDA drive moved with SCL high"); // R9

    AST_ENABLE_FOLLOWS_REG: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_en) |-> !$stable(cfg_regs)) else $error("enable moved alone"); // R8

endmodule

bind clkdrv_cfg_target clkdrv_cfg_target_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .cfg_regs (cfg_regs),
    .out_en   (out_en)
);

// File: tb/sim_clkdrv_cfg_target.sv
module sim_clkdrv_cfg_target;
    import clkcfg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 20;
    localparam int NREG       = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scl_c = 1'b1;
    logic              sda_c = 1'b1;
    logic              sda_line;
    logic              sda_oe;
    logic [NREG*8-1:0] cfg_regs;
    logic [NOUT-1:0]   out_en;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    byte_t m [NREG];
    byte_t exp_q [$];
    byte_t got_q [$];
    string tag_q [$];
    byte_t wq [$];

    assign sda_line = sda_c & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    clkdrv_cfg_target #(.NREG(NREG)) u0 (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_c),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs),
        .out_en   (out_en)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [NOUT-1:0] exp_en();
        logic [NOUT-1:0] e;
        e[0] = m[5][7]; e[1] = m[5][2]; e[2] = m[5][6]; e[3] = m[5][5];
        e[4] = m[5][4]; e[9] = m[5][3];
        e[5] = m[6][1]; e[6] = m[6][2]; e[7] = m[6][3]; e[8] = m[6][4];
        return e;
    endfunction

    task automatic chk_regs(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, 32'(cfg_regs[i*8 +: 8]), 32'(m[i]));
        chk({tag, " R8 enables"}, 32'(out_en), 32'(exp_en()));
    endtask

    task automatic bus_start();
        sda_c = 1'b1; hold(QTR);
        scl_c = 1'b1; hold(QTR);
        sda_c = 1'b0; hold(QTR);
        scl_c = 1'b0; hold(QTR);
    endtask

    task automatic bus_stop();
        sda_c = 1'b0; hold(QTR);
        scl_c = 1'b1; hold(QTR);
        sda_c = 1'b1; hold(QTR);
    endtask

    task automatic send_bits(input byte_t b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_c = b[i]; hold(QTR);
            scl_c = 1'b1; hold(QTR);
            scl_c = 1'b0; hold(QTR);
        end
    endtask

    task automatic send_byte(input byte_t b, output logic ack);
        send_bits(b, 8);
        sda_c = 1'b1; hold(QTR);
        scl_c = 1'b1; hold(QTR/2);
        ack = !sda_line;
        hold(QTR/2);
        scl_c = 1'b0; hold(QTR);
    endtask

    task automatic recv_byte(output byte_t b, input logic nack);
        for (int i = 7; i >= 0; i--) begin
            hold(QTR);
            scl_c = 1'b1; hold(QTR/2);
            b[i] = sda_line;
            hold(QTR/2);
            scl_c = 1'b0;
        end
        sda_c = nack; hold(QTR);
        scl_c = 1'b1; hold(QTR);
        scl_c = 1'b0; hold(1);
        sda_c = 1'b1; hold(QTR);
    endtask

    // write: address, command, count, then the bytes queued in wq
    task automatic do_write();
        logic ack;
        bus_start();
        send_byte(8'hD4, ack);  chk("R1 write address ack", 32'(ack), 1);
        send_byte(8'hC3, ack);  chk("R2 command ack", 32'(ack), 1);
        send_byte(8'h05, ack);  chk("R2 count ack", 32'(ack), 1);
        for (int k = 0; k < wq.size(); k++) begin
            send_byte(wq[k], ack);
            chk("R3 data ack", 32'(ack), 1);
            if (k < NREG - 1) m[k] = wq[k];
            else if (k == NREG - 1) m[k] = wq[k] & 8'h1F;
        end
        bus_stop();
        wq.delete();
    endtask

    // read n bytes after the address; expected values go to the scoreboard
    task automatic do_read(input int n);
        logic  ack;
        byte_t b;
        bus_start();
        send_byte(8'hD5, ack);
        chk("R1 read address ack", 32'(ack), 1);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(k == 0 ? 8'h07 : (k <= NREG ? m[k-1] : 8'hFF));
            tag_q.push_back("R7 read byte");
            recv_byte(b, k == n - 1);
            got_q.push_back(b);
        end
        chk("R7 R9 released after NACK", 32'(sda_oe), 0);
        bus_stop();
    endtask

    always @(negedge clk) begin
        if (got_q.size() > 0) begin
            byte_t g;
            byte_t e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, 32'(g), 32'(e));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        byte_t b;
        for (int i = 0; i < NREG; i++) m[i] = (i == NREG - 1) ? 8'h1F : 8'hFF;
        hold(5);
        rst = 1'b0;
        hold(5);
        chk_regs("R5 reset");
        chk("R9 idle release", 32'(sda_oe), 0);

        do_read(9);

        // command and count only: nothing changes
        do_write();
        chk_regs("R2 no change");

        // two data bytes then STOP
        wq.push_back(8'h12); wq.push_back(8'h34);
        do_write();
        chk_regs("R3 R4 two bytes");

        // full write plus two extra bytes past the last register
        wq.push_back(8'hA1); wq.push_back(8'hB2); wq.push_back(8'hC3);
        wq.push_back(8'hD4); wq.push_back(8'hE5); wq.push_back(8'h5A);
        wq.push_back(8'h0A); wq.push_back(8'h99); wq.push_back(8'h88);
        do_write();
        chk_regs("R3 full and overflow");
        chk("R6 protected bits", 32'(cfg_regs[NREG*8-1 -: 3]), 0);

        // all ones into the last register
        for (int i = 0; i < NREG; i++) wq.push_back(i == NREG - 1 ? 8'hFF : 8'h00);
        do_write();
        chk_regs("R6 R8 zeros and locked");

        // whole byte, then a byte cut by STOP
        bus_start();
        send_byte(8'hD4, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_byte(8'h77, ack); m[0] = 8'h77;
        send_bits(8'h3C, 4);
        sda_c = 1'b0; hold(QTR);
        bus_stop();
        chk_regs("R4 partial byte");

        // wrong addresses
        bus_start();
        send_byte(8'hA8, ack);
        chk("R1 foreign write nack", 32'(ack), 0);
        send_byte(8'h00, ack); send_byte(8'h00, ack); send_byte(8'h11, ack);
        chk("R1 foreign stays silent", 32'(ack), 0);
        bus_stop();
        chk_regs("R1 foreign ignored");
        bus_start();
        send_byte(8'hD7, ack);
        chk("R1 foreign read nack", 32'(ack), 0);
        bus_stop();

        // repeated START in the middle of a write
        bus_start();
        send_byte(8'hD4, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_bits(8'h00, 3);
        sda_c = 1'b1; hold(QTR);
        bus_start();
        send_byte(8'hD5, ack);
        chk("R10 restart address ack", 32'(ack), 1);
        recv_byte(b, 1'b0);
        chk("R10 count after restart", 32'(b), 32'h07);
        recv_byte(b, 1'b1);
        chk("R10 reg0 kept", 32'(b), 32'(m[0]));
        bus_stop();
        chk_regs("R10 no change");

        do_read(10);

        wait (got_q.size() == 0);
        hold(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule